// File: doc/BRIEF.md
# Split-word interrupt controller register file

This block is the software-facing half of a 51-line interrupt controller. A capture stage elsewhere turns the interrupt lines into a raw pending vector. This block holds the per-line enable, route-select and polarity state. It offers read views of the pending and status vectors. It raises two registered outputs: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`).

Every 51-bit quantity is reached as two 32-bit words on a simple bus with no wait states. Address bit 2 picks the upper word, which carries lines 50..32 in data bits 18..0. Read data is combinational on the address. A write takes effect at the rising clock edge on which `bus_wr` is high.

Enables are changed through separate set and clear addresses, so no read-modify-write sequence is needed. Writing the edge-clear address sends a one-cycle clear mask back to the capture stage. The mask only ever touches edge-sensitive lines.

Top module: `ivc_regfile`

## Requirements
- R1: After a synchronous reset, select and enable read zero, `irq_o`, `fiq_o` and `edge_clr` are low, and `evt_pol` equals 51'h5F07FFF8FFFF.
- R2: Addresses below 0x80 read as zero, and writes to them change no state.
- R3: Address bit 2 selects the upper word. Upper reads return lines 50..32 in bits 18..0 with bits 31..19 zero. Upper write data is masked to bits 18..0.
- R4: A write to 0xA0/0xA4 ORs the data into enable. A write to 0xA8/0xAC clears the enable bits where the data is one.
- R5: A write to 0x98/0x9C replaces only the addressed word of select, and the other word is kept.
- R6: Polarity (`evt_pol`, read at 0xD0/0xD4) changes only on a write to 0xD4, where data bits 18..15 replace lines 50..47. A write to 0xD0 is ignored.
- R7: The following reads are defined:
  - 0x80/0x84 return raw & enable & ~select.
  - 0x88/0x8C return raw & enable & select.
  - 0x90/0x94 return raw.
  - 0xE0/0xE4 return raw & ~sense.
  - Sense at 0xC0/0xC4 reads 51'h1F07FFF8FFFF.
  - Dual-edge at 0xC8/0xCC reads 51'h0F800070000.
- R8: Writes to the status, raw, sense, dual-edge and software-interrupt addresses (0x80-0x94, 0xB0-0xBC, 0xC0-0xCC, 0xE0/0xE4) have no effect. Reads of the clear, software-interrupt, unmapped or misaligned (bits 1..0 not zero) addresses return zero.
- R9: `irq_o` equals the OR of raw & enable & ~select, and `fiq_o` equals the OR of raw & enable & select. Both are taken from the previous cycle's raw input and state.
- R10: A write to 0xD8/0xDC drives `edge_clr` for exactly the next cycle. The value is the data placed at the addressed word, ANDed with ~sense. Otherwise `edge_clr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| raw_pend | input | 51 | Raw pending vector from the capture stage |
| evt_pol | output | 51 | Per-line polarity to the capture stage |
| edge_clr | output | 51 | One-cycle clear mask to the capture stage |
| irq_o | output | 1 | Registered normal interrupt |
| fiq_o | output | 1 | Registered fast interrupt |

## Verification
The properties assume that `bus_addr`, `bus_wr` and `raw_pend` are defined and synchronous to `clk` whenever reset is low. They also assume `raw_pend` is the only source of pending state, so every output pulse can be traced to the previous cycle's inputs. The stimulus changes every input only at the falling edge and holds all inputs defined from time zero. Addresses are mostly word-aligned, and one misaligned probe is issued on purpose. A pseudo-random phase mixes legacy, mapped and unmapped addresses so that writes land on both words of every register.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    parameter int NLINES = 51;
    parameter int WORD_W = 32;
    parameter int ADDR_W = 8;
    parameter int EVT_WR_N = 4;

    localparam int HI_W      = NLINES - WORD_W;
    localparam int EVT_WR_LO = NLINES - EVT_WR_N;
    localparam int SLOT_W    = ADDR_W - 3;

    localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(8'h80);

    typedef logic [NLINES-1:0] linevec_t;

    localparam linevec_t SENSE_FIX = 51'h1F07FFF8FFFF;
    localparam linevec_t DUAL_FIX  = 51'h0F800070000;
    localparam linevec_t EVT_RST   = 51'h5F07FFF8FFFF;

    typedef enum logic [3:0] {
        K_IRQ_ST, K_FIQ_ST, K_RAW, K_SEL, K_EN_SET, K_EN_CLR, K_SW, K_SW_CLR,
        K_SENSE, K_DUAL, K_EVT, K_EDGE_CLR, K_EDGE_ST, K_NONE
    } regkey_t;

    typedef struct packed {
        logic    hi;
        regkey_t key;
    } access_t;

    // put a bus word at the addressed half of a line vector
    function automatic linevec_t place_word(input logic hi, input logic [WORD_W-1:0] d);
        if (hi) return {d[HI_W-1:0], {WORD_W{1'b0}}};
        return {{HI_W{1'b0}}, d};
    endfunction

    // take the addressed half of a line vector as a bus word
    function automatic logic [WORD_W-1:0] pick_word(input logic hi, input linevec_t v);
        if (hi) return {{(WORD_W-HI_W){1'b0}}, v[NLINES-1:WORD_W]};
        return v[WORD_W-1:0];
    endfunction
endpackage

// File: rtl/ivc_decode.sv
module ivc_decode
    import ivc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output access_t           acc
);
    logic [ADDR_W-3:0] rel_w;
    logic [SLOT_W-1:0] slot;

    always_comb begin
        rel_w  = addr[ADDR_W-1:2] - WIN_BASE[ADDR_W-1:2];
        slot   = rel_w[ADDR_W-3:1];
        acc.hi = rel_w[0];
        if (addr < WIN_BASE || addr[1:0] != 2'b00) begin
            acc.key = K_NONE;
        end else begin
            case (int'(slot))
                0:       acc.key = K_IRQ_ST;
                1:       acc.key = K_FIQ_ST;
                2:       acc.key = K_RAW;
                3:       acc.key = K_SEL;
                4:       acc.key = K_EN_SET;
                5:       acc.key = K_EN_CLR;
                6:       acc.key = K_SW;
                7:       acc.key = K_SW_CLR;
                8:       acc.key = K_SENSE;
                9:       acc.key = K_DUAL;
                10:      acc.key = K_EVT;
                11:      acc.key = K_EDGE_CLR;
                12:      acc.key = K_EDGE_ST;
                default: acc.key = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ivc_state.sv
module ivc_state
    import ivc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  access_t           acc,
    input  logic [WORD_W-1:0] wdata,
    output linevec_t          en_q,
    output linevec_t          sel_q,
    output linevec_t          evt_q,
    output linevec_t          clr_q
);
    linevec_t wvec;

    assign wvec = place_word(acc.hi, wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            sel_q <= '0;
            evt_q <= EVT_RST;
            clr_q <= '0;
        end else begin
            clr_q <= '0;
            if (wr) begin
                case (acc.key)
                    K_SEL: begin
                        if (acc.hi) sel_q[NLINES-1:WORD_W] <= wdata[HI_W-1:0];
                        else        sel_q[WORD_W-1:0]      <= wdata;
                    end
                    K_EN_SET:   en_q <= en_q | wvec;
                    K_EN_CLR:   en_q <= en_q & ~wvec;
                    K_EVT: begin
                        if (acc.hi)
                            evt_q[NLINES-1:EVT_WR_LO] <= wdata[HI_W-1:HI_W-EVT_WR_N];
                    end
                    K_EDGE_CLR: clr_q <= wvec & ~SENSE_FIX;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ivc_route.sv
module ivc_route
    import ivc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  linevec_t raw,
    input  linevec_t en,
    input  linevec_t sel,
    output linevec_t irq_st,
    output linevec_t fiq_st,
    output logic     irq_q,
    output logic     fiq_q
);
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        assign irq_st[i] = raw[i] & en[i] & ~sel[i];
        assign fiq_st[i] = raw[i] & en[i] &  sel[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
        end else begin
            irq_q <= |irq_st;
            fiq_q <= |fiq_st;
        end
    end
endmodule

// File: rtl/ivc_regfile.sv
module ivc_regfile
    import ivc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic [WORD_W-1:0]         bus_wdata,
    output logic [WORD_W-1:0]         bus_rdata,
    input  logic [ivc_pkg::NLINES-1:0] raw_pend,
    output logic [ivc_pkg::NLINES-1:0] evt_pol,
    output logic [ivc_pkg::NLINES-1:0] edge_clr,
    output logic                      irq_o,
    output logic                      fiq_o
);
    access_t  acc;
    linevec_t en_q, sel_q, irq_st, fiq_st, rd_vec;

    ivc_decode u_dec (
        .addr (bus_addr),
        .acc  (acc)
    );

    ivc_state u_state (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .acc   (acc),
        .wdata (bus_wdata),
        .en_q  (en_q),
        .sel_q (sel_q),
        .evt_q (evt_pol),
        .clr_q (edge_clr)
    );

    ivc_route u_route (
        .clk    (clk),
        .rst    (rst),
        .raw    (raw_pend),
        .en     (en_q),
        .sel    (sel_q),
        .irq_st (irq_st),
        .fiq_st (fiq_st),
        .irq_q  (irq_o),
        .fiq_q  (fiq_o)
    );

    always_comb begin
        case (acc.key)
            K_IRQ_ST:  rd_vec = irq_st;
            K_FIQ_ST:  rd_vec = fiq_st;
            K_RAW:     rd_vec = raw_pend;
            K_SEL:     rd_vec = sel_q;
            K_EN_SET:  rd_vec = en_q;
            K_SENSE:   rd_vec = SENSE_FIX;
            K_DUAL:    rd_vec = DUAL_FIX;
            K_EVT:     rd_vec = evt_pol;
            K_EDGE_ST: rd_vec = raw_pend & ~SENSE_FIX;
            default:   rd_vec = '0;
        endcase
        bus_rdata = pick_word(acc.hi, rd_vec);
    end
endmodule

// File: rtl/ivc_regfile_chk.sv
module ivc_regfile_chk
    import ivc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_rdata,
    input linevec_t          raw_pend,
    input linevec_t          en_q,
    input linevec_t          sel_q,
    input linevec_t          evt_pol,
    input linevec_t          edge_clr,
    input logic              irq_o,
    input logic              fiq_o
);
    logic              legacy, aligned, clr_hit, evt_lo_hit;
    logic [ADDR_W-3:0] rel_w;

    assign legacy     = bus_addr < WIN_BASE;
    assign aligned    = bus_addr[1:0] == 2'b00;
    assign rel_w      = bus_addr[ADDR_W-1:2] - WIN_BASE[ADDR_W-1:2];
    assign clr_hit    = !legacy && aligned && rel_w[ADDR_W-3:1] == SLOT_W'(11);
    assign evt_lo_hit = !legacy && aligned && rel_w == (ADDR_W-2)'(20);

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(|(raw_pend & en_q & ~sel_q)));

    // R9
    fiq_src_chk: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> $past(|(raw_pend & en_q & sel_q)));

    // R10
    clr_src_chk: assert property (@(posedge clk) disable iff (rst)
        (|edge_clr) |-> $past(bus_wr && clr_hit));

    // R2
    legacy_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && legacy) |=> ($stable(en_q) && $stable(sel_q) && $stable(evt_pol)));

    // R2
    legacy_rd_chk: assert property (@(posedge clk) disable iff (rst)
        legacy |-> (bus_rdata == '0));

    // R6
    evt_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && evt_lo_hit) |=> $stable(evt_pol));
endmodule

bind ivc_regfile ivc_regfile_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .raw_pend  (raw_pend),
    .en_q      (en_q),
    .sel_q     (sel_q),
    .evt_pol   (evt_pol),
    .edge_clr  (edge_clr),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
);

// File: tb/sim_ivc_regfile.sv
module sim_ivc_regfile;
    localparam int CLK_PERIOD = 10;
    localparam logic [50:0] SENSE_C = 51'h1F07FFF8FFFF;
    localparam logic [50:0] DUAL_C  = 51'h0F800070000;
    localparam logic [50:0] EVT_C   = 51'h5F07FFF8FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [50:0] raw_pend = '0;
    logic [50:0] evt_pol, edge_clr;
    logic        irq_o, fiq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [50:0] m_en, m_sel, m_evt, m_clr;
    logic        m_irq, m_fiq;

    always #(CLK_PERIOD/2) clk = ~clk;

    ivc_regfile u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .raw_pend(raw_pend),
        .evt_pol(evt_pol), .edge_clr(edge_clr), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(input logic [7:0] a, input logic [50:0] raw);
        logic [7:0]  rel;
        logic [50:0] v;
        if (a < 8'h80 || a[1:0] != 2'b00) return 32'h0;
        rel = a - 8'h80;
        case (int'(rel[7:3]))
            0:  v = raw & m_en & ~m_sel;
            1:  v = raw & m_en & m_sel;
            2:  v = raw;
            3:  v = m_sel;
            4:  v = m_en;
            8:  v = SENSE_C;
            9:  v = DUAL_C;
            10: v = m_evt;
            12: v = raw & ~SENSE_C;
            default: v = '0;
        endcase
        return rel[2] ? {13'h0, v[50:32]} : v[31:0];
    endfunction

    // one bus cycle: drive, compare against the model, then advance the model
    task automatic cyc(input bit wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [50:0] raw, input string tag);
        logic [7:0]  rel;
        logic [50:0] wv;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; raw_pend = raw;
        #1;
        chk(tag, 64'(bus_rdata), 64'(mread(a, raw)));
        chk("R9 irq_o", 64'(irq_o), 64'(m_irq));
        chk("R9 fiq_o", 64'(fiq_o), 64'(m_fiq));
        chk("R10 edge_clr", 64'(edge_clr), 64'(m_clr));
        chk("R6 evt_pol", 64'(evt_pol), 64'(m_evt));
        m_irq = |(raw & m_en & ~m_sel);
        m_fiq = |(raw & m_en & m_sel);
        m_clr = '0;
        if (wr && a >= 8'h80 && a[1:0] == 2'b00) begin
            rel = a - 8'h80;
            wv  = rel[2] ? {d[18:0], 32'h0} : {19'h0, d};
            case (int'(rel[7:3]))
                3:  if (rel[2]) m_sel[50:32] = d[18:0]; else m_sel[31:0] = d;
                4:  m_en = m_en | wv;
                5:  m_en = m_en & ~wv;
                10: if (rel[2]) m_evt[50:47] = d[18:15];
                11: m_clr = wv & ~SENSE_C;
                default: ;
            endcase
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [50:0] raw, input string tag);
        cyc(1'b0, a, 32'h0, raw, tag);
    endtask

    task automatic wrw(input logic [7:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, a, d, '0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] lf;
        m_en = '0; m_sel = '0; m_evt = EVT_C; m_clr = '0; m_irq = 0; m_fiq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(8'h98, '0, "R1 select lo");
        rd(8'h9C, '0, "R1 select hi");
        rd(8'hA0, '0, "R1 enable lo");
        rd(8'hD4, '0, "R1 event hi");

        // R2 legacy window
        wrw(8'h20, 32'hFFFF_FFFF, "R2 legacy write");
        wrw(8'h18, 32'hFFFF_FFFF, "R2 legacy write");
        rd(8'hA0, '0, "R2 enable after legacy write");
        rd(8'h10, 51'h7FFFF_FFFFFFFF, "R2 legacy read");

        // R4 and R3 enable set/clear on both words
        wrw(8'hA0, 32'h0000_00F3, "R4 enable set lo");
        wrw(8'hA4, 32'hFFFF_FFFF, "R3 enable set hi masked");
        rd(8'hA4, '0, "R3 enable hi read");
        wrw(8'hA8, 32'h0000_0003, "R4 enable clear lo");
        rd(8'hA0, '0, "R4 enable lo read");
        wrw(8'hAC, 32'h0004_0001, "R4 enable clear hi");
        rd(8'hA4, '0, "R4 enable hi read");

        // R5 select half replace
        wrw(8'h98, 32'h0000_00F0, "R5 select lo");
        wrw(8'h9C, 32'hFFF0_0005, "R5 select hi");
        wrw(8'h98, 32'h0000_0030, "R5 select lo again");
        rd(8'h9C, '0, "R5 select hi kept");
        rd(8'h98, '0, "R5 select lo read");

        // R7 and R9 status views with several raw patterns
        rd(8'h80, 51'h0000_0000_00F0, "R7 irq status lo");
        rd(8'h88, 51'h0000_0000_00F0, "R7 fiq status lo");
        rd(8'h84, 51'h7FFFF_00000000, "R7 irq status hi");
        rd(8'h8C, 51'h7FFFF_00000000, "R7 fiq status hi");
        rd(8'h90, 51'h5A5A5_A5A5A5A5, "R7 raw lo");
        rd(8'h94, 51'h5A5A5_A5A5A5A5, "R7 raw hi");
        rd(8'hE0, 51'h7FFFF_FFFFFFFF, "R7 edge status lo");
        rd(8'hE4, 51'h7FFFF_FFFFFFFF, "R7 edge status hi");
        rd(8'hC0, '0, "R7 sense lo");
        rd(8'hC4, '0, "R7 sense hi");
        rd(8'hC8, '0, "R7 dual lo");
        rd(8'hCC, '0, "R7 dual hi");
        rd(8'h80, '0, "R9 idle");
        rd(8'h80, '0, "R9 idle");

        // R6 polarity writes
        wrw(8'hD0, 32'hFFFF_FFFF, "R6 event lo ignored");
        rd(8'hD0, '0, "R6 event lo read");
        wrw(8'hD4, 32'hFFFF_FFFF, "R6 event hi set");
        rd(8'hD4, '0, "R6 event hi read");
        wrw(8'hD4, 32'h0000_0000, "R6 event hi clear");
        rd(8'hD4, '0, "R6 event hi read");

        // R8 read-only and write-only addresses
        wrw(8'h80, 32'hFFFF_FFFF, "R8 write irq status");
        wrw(8'h94, 32'hFFFF_FFFF, "R8 write raw");
        wrw(8'hC0, 32'h0, "R8 write sense");
        wrw(8'hCC, 32'h0, "R8 write dual");
        wrw(8'hE0, 32'h0, "R8 write edge status");
        wrw(8'hB0, 32'hFFFF_FFFF, "R8 write sw");
        wrw(8'hB8, 32'hFFFF_FFFF, "R8 write sw clear");
        rd(8'hC0, '0, "R8 sense unchanged");
        rd(8'hB0, '0, "R8 sw read");
        rd(8'hA8, '0, "R8 enable clear read");
        rd(8'hB8, '0, "R8 sw clear read");
        rd(8'hD8, '0, "R8 edge clear read");
        rd(8'hF0, '0, "R8 unmapped read");
        rd(8'h99, '0, "R8 misaligned read");
        rd(8'hA0, '0, "R8 enable unchanged");
        rd(8'h98, '0, "R8 select unchanged");

        // R10 edge clear pulses
        wrw(8'hD8, 32'hFFFF_FFFF, "R10 edge clear lo");
        rd(8'h80, '0, "R10 pulse cycle");
        wrw(8'hDC, 32'hFFFF_FFFF, "R10 edge clear hi");
        wrw(8'hDC, 32'h0000_0F00, "R10 back to back");
        rd(8'h80, '0, "R10 pulse cycle");
        rd(8'h80, '0, "R10 pulse gone");

        // mixed pseudo-random traffic covering every requirement
        lf = 64'hACE1_2468_1357_9BDF;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
            cyc(lf[9], lf[17:10] & 8'hFC, lf[63:32], lf[50:0], "R7 random read");
        end
        rd(8'h80, '0, "R9 drain");
        rd(8'h80, '0, "R9 drain");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule